// File: doc/BRIEF.md
# Dual-Port Collision Busy Arbiter

This block sits beside a shared dual-port memory and watches the select and address lines of its two ports, called A and B. When both ports are selected and present the same address in the same cycle, it lets one of them keep the location and flags the other as busy. A write from the busy side is suppressed before it reaches the array. Only the select and address of each port take part in the decision. The read/write direction plays no part in it.

The grant goes to the port that was already at that address in the previous cycle. That port keeps the grant for as long as the collision continues at that address. When both ports arrive at a fresh shared address in the same cycle, port A wins. A mode input selects the role. In master mode the block drives its busy pins. In slave mode the block does not arbitrate. Its busy pins then act as active-low write-inhibit inputs, so several slave instances can follow the decision of one master.

Each port gets a gated write enable. A combined busy flag is also provided, for use as an error interrupt. All outputs are combinational from the current inputs and one cycle of history. There is no data path, so there is no valid/ready interface, and back-pressure does not apply.

Top module: `dp_busy_arbiter`

## Requirements
- R1: In master mode, a busy flag (pin low) is raised on at most one port. A flag is raised exactly when both ports are enabled and their addresses match on every bit.
- R2: In master mode, when both ports reach a shared address in the same cycle and neither held it in the previous cycle, port A wins and port B is flagged busy.
- R3: In master mode, when one port was enabled at an address in the previous cycle and the other port now arrives at it, the earlier port wins and the arriving port is flagged busy.
- R4: While a collision persists at the same address, the winner does not change. Once the winner leaves, the remaining port is no longer busy.
- R5: The arbitration outcome does not depend on the write inputs (1 = write, 0 = read) of either port.
- R6: The write enable of a port that is flagged busy is 0. The winning port's write enable equals its enable ANDed with its write input.
- R7: Without a collision, each port's write enable equals its enable ANDed with its write input.
- R8: In slave mode (master_mode = 0), a low inhibit input forces that port's write enable to 0, and a high inhibit input leaves the enable as in R7. Both busy output pins stay high in this mode.
- R9: In slave mode, matching addresses on both ports do not gate either write.
- R10: any_busy_o is 1 exactly when at least one port is busy. In master mode that means a port is flagged busy. In slave mode it means a port has its inhibit input held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the history registers |
| master_mode | input | 1 | 1 = master (arbitrate, drive busy); 0 = slave (busy lines are inhibit inputs) |
| a_en | input | 1 | Port A select |
| a_addr | input | ADDR_W | Port A address |
| a_wr | input | 1 | Port A write request (1 = write, 0 = read) |
| b_en | input | 1 | Port B select |
| b_addr | input | ADDR_W | Port B address |
| b_wr | input | 1 | Port B write request (1 = write, 0 = read) |
| a_busy_n_i | input | 1 | Port A write inhibit in slave mode, active low |
| b_busy_n_i | input | 1 | Port B write inhibit in slave mode, active low |
| a_busy_n_o | output | 1 | Port A busy flag in master mode, active low |
| b_busy_n_o | output | 1 | Port B busy flag in master mode, active low |
| a_we_o | output | 1 | Port A gated write enable |
| b_we_o | output | 1 | Port B gated write enable |
| any_busy_o | output | 1 | OR of both ports' busy conditions |

## Verification
The bench builds the block with ADDR_W = 8. This makes it cheap to place addresses that differ only in the most significant bit, which confirms that the match compares the full width and not a truncated slice. With a narrow address, the bench also reuses a handful of locations across fresh, incumbent and persistent collisions. This steps the one-cycle history through every branch of the winner choice, and it switches between master and slave mode mid-run.

// File: rtl/dpba_pkg.sv
package dpba_pkg;
  typedef enum logic {
    PORT_A = 1'b0,
    PORT_B = 1'b1
  } port_e;

  localparam int NPORTS = 2;
endpackage

// File: rtl/dpba_collide.sv
module dpba_collide #(
  parameter int ADDR_W = 14
) (
  input  logic              a_en,
  input  logic              b_en,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [ADDR_W-1:0] b_addr,
  output logic              hit
);
  // A collision needs both selects and a full-width address match.
  always_comb hit = a_en && b_en && (a_addr == b_addr);
endmodule

// File: rtl/dpba_grant_track.sv
module dpba_grant_track
  import dpba_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_en,
  input  logic              b_en,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic              hit,
  output port_e             winner
);
  logic              prev_a_en, prev_b_en, prev_hit;
  logic [ADDR_W-1:0] prev_a_addr, prev_b_addr;
  port_e             prev_win;
  logic              a_held, b_held, carry_on;

  always_comb begin
    a_held   = prev_a_en && (prev_a_addr == a_addr);
    b_held   = prev_b_en && (prev_b_addr == b_addr);
    // Last cycle collided, and this cycle still sits at that same location.
    carry_on = prev_hit && a_held;
    if (carry_on)    winner = prev_win;
    else if (a_held) winner = PORT_A;
    else if (b_held) winner = PORT_B;
    else             winner = PORT_A;   // fixed tie-break for a fresh collision
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_a_en   <= 1'b0;
      prev_b_en   <= 1'b0;
      prev_hit    <= 1'b0;
      prev_a_addr <= '0;
      prev_b_addr <= '0;
      prev_win    <= PORT_A;
    end else begin
      prev_a_en   <= a_en;
      prev_b_en   <= b_en;
      prev_hit    <= hit;
      prev_a_addr <= a_addr;
      prev_b_addr <= b_addr;
      prev_win    <= hit ? winner : PORT_A;
    end
  end
endmodule

// File: rtl/dpba_wr_gate.sv
module dpba_wr_gate (
  input  logic master_mode,
  input  logic en,
  input  logic wr,
  input  logic arb_busy,
  input  logic inhibit_n,
  output logic busy_eff,
  output logic we
);
  // Master: the local arbitration decides. Slave: the external pin decides.
  always_comb begin
    busy_eff = master_mode ? arb_busy : !inhibit_n;
    we       = en && wr && !busy_eff;
  end
endmodule

// File: rtl/dp_busy_arbiter.sv
module dp_busy_arbiter
  import dpba_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              master_mode,
  input  logic              a_en,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic              a_wr,
  input  logic              b_en,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic              b_wr,
  input  logic              a_busy_n_i,
  input  logic              b_busy_n_i,
  output logic              a_busy_n_o,
  output logic              b_busy_n_o,
  output logic              a_we_o,
  output logic              b_we_o,
  output logic              any_busy_o
);
  logic              hit;
  port_e             winner;
  logic [NPORTS-1:0] en_v, wr_v, inh_n_v, arb_busy_v, busy_eff_v, we_v;

  dpba_collide #(.ADDR_W(ADDR_W)) u_collide (
    .a_en(a_en), .b_en(b_en), .a_addr(a_addr), .b_addr(b_addr), .hit(hit)
  );

  dpba_grant_track #(.ADDR_W(ADDR_W)) u_track (
    .clk(clk), .rst_n(rst_n), .a_en(a_en), .b_en(b_en),
    .a_addr(a_addr), .b_addr(b_addr), .hit(hit), .winner(winner)
  );

  always_comb begin
    en_v          = {b_en, a_en};
    wr_v          = {b_wr, a_wr};
    inh_n_v       = {b_busy_n_i, a_busy_n_i};
    arb_busy_v[0] = hit && (winner == PORT_B);
    arb_busy_v[1] = hit && (winner == PORT_A);
  end

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    dpba_wr_gate u_gate (
      .master_mode(master_mode), .en(en_v[p]), .wr(wr_v[p]),
      .arb_busy(arb_busy_v[p]), .inhibit_n(inh_n_v[p]),
      .busy_eff(busy_eff_v[p]), .we(we_v[p])
    );
  end

  always_comb begin
    a_busy_n_o = master_mode ? !arb_busy_v[0] : 1'b1;
    b_busy_n_o = master_mode ? !arb_busy_v[1] : 1'b1;
    a_we_o     = we_v[0];
    b_we_o     = we_v[1];
    any_busy_o = |busy_eff_v;
  end
endmodule

// File: rtl/dp_busy_arbiter_chk.sv
module dp_busy_arbiter_chk #(
  parameter int ADDR_W = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              master_mode,
  input logic              a_en,
  input logic [ADDR_W-1:0] a_addr,
  input logic              a_wr,
  input logic              b_en,
  input logic [ADDR_W-1:0] b_addr,
  input logic              b_wr,
  input logic              a_busy_n_i,
  input logic              b_busy_n_i,
  input logic              a_busy_n_o,
  input logic              b_busy_n_o,
  input logic              a_we_o,
  input logic              b_we_o,
  input logic              any_busy_o
);
  logic same;
  always_comb same = a_en && b_en && (a_addr == b_addr);

  // R1
  single_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    master_mode |-> (a_busy_n_o || b_busy_n_o));
  // R1
  busy_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode && (!a_busy_n_o || !b_busy_n_o)) |-> same);
  // R1
  hit_gives_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode && same) |-> (a_busy_n_o != b_busy_n_o));
  // R4
  winner_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode && same && $past(master_mode) && $past(same) && $stable(a_addr))
      |-> $stable(a_busy_n_o));
  // R6
  busy_blocks_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode && (!a_busy_n_o || !b_busy_n_o))
      |-> ((a_busy_n_o || !a_we_o) && (b_busy_n_o || !b_we_o)));
  // R7
  we_needs_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_we_o |-> (a_en && a_wr)) and (b_we_o |-> (b_en && b_wr)));
  // R8
  slave_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !master_mode |-> ((a_busy_n_i || !a_we_o) && (b_busy_n_i || !b_we_o)
                      && a_busy_n_o && b_busy_n_o));
  // R10
  any_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    master_mode |-> (any_busy_o == (!a_busy_n_o || !b_busy_n_o)));
endmodule

bind dp_busy_arbiter dp_busy_arbiter_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .master_mode(master_mode),
  .a_en(a_en), .a_addr(a_addr), .a_wr(a_wr),
  .b_en(b_en), .b_addr(b_addr), .b_wr(b_wr),
  .a_busy_n_i(a_busy_n_i), .b_busy_n_i(b_busy_n_i),
  .a_busy_n_o(a_busy_n_o), .b_busy_n_o(b_busy_n_o),
  .a_we_o(a_we_o), .b_we_o(b_we_o), .any_busy_o(any_busy_o)
);

// File: tb/dp_busy_arbiter_bench.sv
module dp_busy_arbiter_bench;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          master_mode = 1'b1;
  logic          a_en = 1'b0, b_en = 1'b0, a_wr = 1'b0, b_wr = 1'b0;
  logic [AW-1:0] a_addr = '0, b_addr = '0;
  logic          a_busy_n_i = 1'b1, b_busy_n_i = 1'b1;
  logic          a_busy_n_o, b_busy_n_o, a_we_o, b_we_o, any_busy_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  typedef struct {
    bit    a_busy, b_busy, a_we, b_we, any;
    string tag;
  } exp_t;
  exp_t exp_q[$];

  always #4 clk = ~clk;

  dp_busy_arbiter #(.ADDR_W(AW)) u_dp_busy_arbiter (
    .clk(clk), .rst_n(rst_n), .master_mode(master_mode),
    .a_en(a_en), .a_addr(a_addr), .a_wr(a_wr),
    .b_en(b_en), .b_addr(b_addr), .b_wr(b_wr),
    .a_busy_n_i(a_busy_n_i), .b_busy_n_i(b_busy_n_i),
    .a_busy_n_o(a_busy_n_o), .b_busy_n_o(b_busy_n_o),
    .a_we_o(a_we_o), .b_we_o(b_we_o), .any_busy_o(any_busy_o)
  );

  task automatic cmp(input string tag, input string what, input bit act, input bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus and queues what the requirements predict.
  task automatic step(input bit m, input bit ae, input logic [AW-1:0] aa, input bit aw,
                      input bit be, input logic [AW-1:0] ba, input bit bw,
                      input bit ani, input bit bni,
                      input bit xa_busy, input bit xb_busy, input bit xa_we, input bit xb_we,
                      input bit xany, input string tag);
    exp_t e;
    @(negedge clk);
    #1;
    master_mode = m; a_en = ae; a_addr = aa; a_wr = aw;
    b_en = be; b_addr = ba; b_wr = bw; a_busy_n_i = ani; b_busy_n_i = bni;
    e.a_busy = xa_busy; e.b_busy = xb_busy; e.a_we = xa_we; e.b_we = xb_we;
    e.any = xany; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // Monitor: samples mid-cycle, after the driver has settled the inputs.
  initial begin
    forever begin
      @(negedge clk);
      #3;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        cmp(e.tag, "a_busy_n_o", a_busy_n_o, !e.a_busy);
        cmp(e.tag, "b_busy_n_o", b_busy_n_o, !e.b_busy);
        cmp(e.tag, "a_we_o", a_we_o, e.a_we);
        cmp(e.tag, "b_we_o", b_we_o, e.b_we);
        cmp(e.tag, "any_busy_o", any_busy_o, e.any);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // Reset state: nothing selected, no busy, no writes.
    step(1, 0, 8'h00, 0, 0, 8'h00, 0, 1, 1, 0, 0, 0, 0, 0, "reset");
    @(negedge clk);
    rst_n = 1'b1;
    // R7: distinct addresses, both write.
    step(1, 1, 8'h10, 1, 1, 8'h20, 1, 1, 1, 0, 0, 1, 1, 0, "R7 no collision");
    // R1: addresses differ only in the top bit.
    step(1, 1, 8'h85, 1, 1, 8'h05, 1, 1, 1, 0, 0, 1, 1, 0, "R1 msb differs");
    // R1: same address but B not selected.
    step(1, 1, 8'h03, 1, 0, 8'h03, 1, 1, 1, 0, 0, 1, 0, 0, "R1 one disabled");
    // R2 R6: fresh collision at 05, A wins.
    step(1, 1, 8'h05, 1, 1, 8'h05, 1, 1, 1, 0, 1, 1, 0, 1, "R2 R6 fresh tie");
    // R4: collision persists, winner kept.
    step(1, 1, 8'h05, 1, 1, 8'h05, 1, 1, 1, 0, 1, 1, 0, 1, "R4 persist");
    // R4: winner A leaves; B alone, not busy.
    step(1, 0, 8'h05, 0, 1, 8'h05, 1, 1, 1, 0, 0, 0, 1, 0, "R4 release");
    // R3: B held 05, A arrives and is busy.
    step(1, 1, 8'h05, 1, 1, 8'h05, 1, 1, 1, 1, 0, 0, 1, 1, "R3 B incumbent");
    // R4: B keeps the grant.
    step(1, 1, 8'h05, 1, 1, 8'h05, 1, 1, 1, 1, 0, 0, 1, 1, "R4 B persists");
    step(1, 0, 8'h00, 0, 0, 8'h00, 0, 1, 1, 0, 0, 0, 0, 0, "R7 idle");
    // R3 R5: A reads at 07 first; B then writes there and is busy.
    step(1, 1, 8'h07, 0, 0, 8'h00, 0, 1, 1, 0, 0, 0, 0, 0, "R3 A alone read");
    step(1, 1, 8'h07, 0, 1, 8'h07, 1, 1, 1, 0, 1, 0, 0, 1, "R3 R5 A reader holds");
    // R2 R5: both move to fresh 09 reading; A wins regardless of direction.
    step(1, 1, 8'h09, 0, 1, 8'h09, 0, 1, 1, 0, 1, 0, 0, 1, "R2 R5 read tie");
    // R1: they split apart.
    step(1, 1, 8'h09, 1, 1, 8'h0A, 1, 1, 1, 0, 0, 1, 1, 0, "R1 split");
    // R8 R9: slave mode, collision ignored, inhibits high.
    step(0, 1, 8'h03, 1, 1, 8'h03, 1, 1, 1, 0, 0, 1, 1, 0, "R8 R9 slave no gate");
    // R8 R10: slave, A inhibited.
    step(0, 1, 8'h03, 1, 1, 8'h03, 1, 0, 1, 0, 0, 0, 1, 1, "R8 R10 slave inhibit A");
    // R8 R10: slave, B inhibited.
    step(0, 1, 8'h04, 1, 1, 8'h06, 1, 1, 0, 0, 0, 1, 0, 1, "R8 R10 slave inhibit B");
    // R8: back in master, the inhibit pins are ignored.
    step(1, 1, 8'h04, 1, 1, 8'h06, 1, 0, 0, 0, 0, 1, 1, 0, "R8 master ignores inhibit");
    // R10: master collision at a fresh location raises any_busy.
    step(1, 1, 8'h0B, 1, 1, 8'h0B, 0, 1, 1, 0, 1, 1, 0, 1, "R10 any busy");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule